// File: doc/BRIEF.md
# Identifier-Tagged Translation Buffer with Two Page Sections

This block is a fully associative address translation cache. It turns 48-bit virtual addresses into 40-bit physical addresses. Every entry is tagged with an address-space identifier, so translations from several guests, processes and the hypervisor can stay resident at the same time. A context switch therefore does not empty the buffer. Storage has two sections. The first holds 4 KB pages. The second holds large pages, and each large entry is either 2 MB or 4 MB. Both sections are searched in the same cycle, and the result is registered and returned one cycle after the request.

Entries are loaded through a fill port by miss-handling software, which is outside the block. A fill goes to the section that matches its page size. It lands in the lowest free slot of that section, or in that section's round-robin victim when the section is full. If the fill overlaps a valid entry that the same lookup would also hit, the old translation is replaced rather than duplicated, so a lookup can never hit twice.

Two commands remove entries. One removes a single identifier and keeps global entries. The other clears the whole buffer.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid, so every lookup misses, and `rsp_valid` is low until a lookup is issued.
- R2: A lookup presented with `lk_valid` high at a clock edge gives exactly one response, with `rsp_valid` high, at the following edge. No response appears without a request.
- R3: A 4 KB entry hits when its stored `va[47:12]` equals the lookup's. The physical address is then `{stored pa[39:12], lk_va[11:0]}`, and `rsp_perm` returns the stored permission bits.
- R4: A non-global entry hits only when the request identifier equals the stored identifier.
- R5: An entry filled with `fill_global` = 1 hits under any request identifier.
- R6: A large fill (`fill_large` = 1) with `fill_4m` = 0 maps 2 MB. It compares `va[47:21]` and returns `{pa[39:21], va[20:0]}`. With `fill_4m` = 1 it maps 4 MB, compares `va[47:22]` and returns `{pa[39:22], va[21:0]}`. The low physical bits given at fill time are ignored.
- R7: `flush_id_valid` invalidates every non-global entry whose identifier equals `flush_id`. Entries with other identifiers, and all global entries, stay valid.
- R8: `flush_all` invalidates every entry, global ones included. A fill presented in the same cycle is dropped.
- R9: When a section has free slots, a fill takes the lowest-indexed free slot. When the section is full, it replaces a per-section round-robin victim. The victim pointer starts at index 0 and moves forward by one only when a fill uses it.
- R10: A fill that overlaps a valid entry in its own section is written over that entry. Overlap means both address ranges cover a common page and the identifiers match, or either side is global. The old mapping disappears and no free slot is used.
- R11: A fill also invalidates every overlapping, identifier-matching entry in the other section. A small page written inside a resident large page removes that large page.
- R12: A fill and an identifier flush in the same cycle both take effect. The newly filled entry stays valid even when its identifier equals `flush_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_va | input | 48 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space identifier |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Translation found |
| rsp_pa | output | 40 | Translated physical address |
| rsp_perm | output | 4 | Permission bits of the hitting entry |
| fill_valid | input | 1 | Fill strobe |
| fill_va | input | 48 | Fill virtual page address |
| fill_pa | input | 40 | Fill physical frame address |
| fill_asid | input | 8 | Fill identifier |
| fill_global | input | 1 | Entry ignores identifiers and survives identifier flushes |
| fill_large | input | 1 | 1: large-page section, 0: 4 KB section |
| fill_4m | input | 1 | Large page size: 1 = 4 MB, 0 = 2 MB |
| fill_perm | input | 4 | Permission bits stored with the entry |
| flush_id_valid | input | 1 | Identifier flush strobe |
| flush_id | input | 8 | Identifier to flush |
| flush_all | input | 1 | Invalidate every entry |

## Verification
Lookups are run against 4 KB, 2 MB and 4 MB mappings. Addresses are picked just inside and just outside each page, which separates tag widths that are right from ones that are off by one bit. The fill data carries junk in the low frame bits, which shows whether offset bits are taken from the lookup or from the stored frame. The same address is looked up under a matching identifier, a different identifier and a global entry, to separate the identifier rules. Further sequences cover flushes alone and flushes together with a fill, a refill of a resident page, a small page written inside a large one, and more than 32 distinct small fills, to expose slot choice and round-robin order.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

   // Page-number bits between the 4 KB boundary and the 4 MB boundary (va[21:12]).
   localparam int SUB_W = 10;

   typedef enum logic [1:0] {
      PG_4K = 2'd0,
      PG_2M = 2'd1,
      PG_4M = 2'd2
   } pg_kind_e;

   // Bits of the sub-field that take part in a compare for a given page size.
   function automatic logic [SUB_W-1:0] sub_mask(input pg_kind_e kind);
      case (kind)
         PG_4K:   sub_mask = '1;
         PG_2M:   sub_mask = SUB_W'(1) << (SUB_W - 1);
         default: sub_mask = '0;
      endcase
   endfunction

endpackage

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int N  = 32,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  valid_vec,
   input  logic          advance,
   output logic          free_found,
   output logic [IW-1:0] pick
);

   if (N < 2) begin : g_chk
      $error("tlb_victim: N must be at least 2");
   end

   logic [IW-1:0] rr_q;
   logic [IW-1:0] free_idx;

   always_comb begin
      free_found = 1'b0;
      free_idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid_vec[i]) begin
            free_found = 1'b1;
            free_idx   = IW'(i);
         end
      end
      pick = free_found ? free_idx : rr_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (advance) begin
         rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
      end
   end

   AST_FREE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
      free_found |-> !valid_vec[pick]); // R9

endmodule

// File: rtl/tlb_section.sv
module tlb_section
   import asid_tlb_pkg::*;
#(
   parameter int N      = 32,
   parameter bit LARGE  = 1'b0,
   parameter int VPN_W  = 36,
   parameter int PPN_W  = 28,
   parameter int ASID_W = 8,
   parameter int PERM_W = 4,
   localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   // lookup
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              hit,
   output logic [PPN_W-1:0]  hit_ppn,
   output logic [PERM_W-1:0] hit_perm,
   // fill
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic              fill_glb,
   input  pg_kind_e          fill_kind,
   input  logic [PERM_W-1:0] fill_perm,
   input  logic              fill_here,
   input  logic              fill_kill,
   // invalidation
   input  logic              flush_all,
   input  logic              flush_id_v,
   input  logic [ASID_W-1:0] flush_id
);

   if (VPN_W <= SUB_W || PPN_W <= SUB_W) begin : g_chk_w
      $error("tlb_section: page-number widths too small");
   end

   logic [N-1:0]        valid_q;
   logic [N-1:0]        glb_q;
   logic [ASID_W-1:0]   asid_q [N];
   logic [VPN_W-1:0]    vpn_q  [N];
   logic [PPN_W-1:0]    ppn_q  [N];
   logic [PERM_W-1:0]   perm_q [N];
   pg_kind_e            kind_w [N];

   // Page size per entry: stored in the large section, fixed in the small one.
   if (LARGE) begin : g_kind_store
      pg_kind_e kind_q [N];
      always_ff @(posedge clk) begin
         for (int i = 0; i < N; i++) begin
            if (fill_here && !flush_all && IW'(i) == tgt) kind_q[i] <= fill_kind;
         end
      end
      always_comb begin
         for (int i = 0; i < N; i++) kind_w[i] = kind_q[i];
      end
   end else begin : g_kind_fixed
      always_comb begin
         for (int i = 0; i < N; i++) kind_w[i] = PG_4K;
      end
   end

   // Compare logic
   logic [N-1:0]       hit_vec;
   logic [N-1:0]       ovl_vec;
   logic               ovl_any;
   logic [IW-1:0]      ovl_idx;
   logic [IW-1:0]      tgt;
   logic               free_found;
   logic [IW-1:0]      vict;
   logic [SUB_W-1:0]   fkm;

   always_comb begin
      fkm      = sub_mask(fill_kind);
      hit_vec  = '0;
      ovl_vec  = '0;
      hit_ppn  = '0;
      hit_perm = '0;
      for (int i = 0; i < N; i++) begin
         logic [SUB_W-1:0] km;
         km = sub_mask(kind_w[i]);
         hit_vec[i] = valid_q[i]
                    && (glb_q[i] || asid_q[i] == lk_asid)
                    && (vpn_q[i][VPN_W-1:SUB_W] == lk_vpn[VPN_W-1:SUB_W])
                    && (((vpn_q[i][SUB_W-1:0] ^ lk_vpn[SUB_W-1:0]) & km) == '0);
         ovl_vec[i] = valid_q[i]
                    && (glb_q[i] || fill_glb || asid_q[i] == fill_asid)
                    && (vpn_q[i][VPN_W-1:SUB_W] == fill_vpn[VPN_W-1:SUB_W])
                    && (((vpn_q[i][SUB_W-1:0] ^ fill_vpn[SUB_W-1:0]) & km & fkm) == '0);
         if (hit_vec[i]) begin
            hit_ppn  = hit_ppn
                     | {ppn_q[i][PPN_W-1:SUB_W],
                        (ppn_q[i][SUB_W-1:0] & km) | (lk_vpn[SUB_W-1:0] & ~km)};
            hit_perm = hit_perm | perm_q[i];
         end
      end
      hit     = |hit_vec;
      ovl_any = |ovl_vec;
      ovl_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (ovl_vec[i]) ovl_idx = IW'(i);
      end
      tgt = ovl_any ? ovl_idx : vict;
   end

   tlb_victim #(.N(N)) u_victim (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_vec  (valid_q),
      .advance    (fill_here && !flush_all && !ovl_any && !free_found),
      .free_found (free_found),
      .pick       (vict)
   );

   // Valid / global state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         glb_q   <= '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            if (flush_all) begin
               valid_q[i] <= 1'b0;
            end else if (fill_here && IW'(i) == tgt) begin
               valid_q[i] <= 1'b1;
               glb_q[i]   <= fill_glb;
            end else if ((fill_here || fill_kill) && ovl_vec[i]) begin
               valid_q[i] <= 1'b0;
            end else if (flush_id_v && !glb_q[i] && asid_q[i] == flush_id) begin
               valid_q[i] <= 1'b0;
            end
         end
      end
   end

   // Payload storage (no reset needed, qualified by valid)
   always_ff @(posedge clk) begin
      for (int i = 0; i < N; i++) begin
         if (fill_here && !flush_all && IW'(i) == tgt) begin
            asid_q[i] <= fill_asid;
            vpn_q[i]  <= fill_vpn;
            ppn_q[i]  <= fill_ppn;
            perm_q[i] <= fill_perm;
         end
      end
   end

   AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R10

   AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (valid_q == '0)); // R8

   AST_GLOBAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_id_v && !flush_all && !fill_here && !fill_kill)
      |=> ((valid_q & glb_q) == $past(valid_q & glb_q))); // R7

   AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_here && !flush_all) |=> (valid_q != '0)); // R12

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
   import asid_tlb_pkg::*;
#(
   parameter int VA_W    = 48,
   parameter int PA_W    = 40,
   parameter int ASID_W  = 8,
   parameter int PERM_W  = 4,
   parameter int SMALL_N = 32,
   parameter int LARGE_N = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [PA_W-1:0]   rsp_pa,
   output logic [PERM_W-1:0] rsp_perm,
   input  logic              fill_valid,
   input  logic [VA_W-1:0]   fill_va,
   input  logic [PA_W-1:0]   fill_pa,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic              fill_global,
   input  logic              fill_large,
   input  logic              fill_4m,
   input  logic [PERM_W-1:0] fill_perm,
   input  logic              flush_id_valid,
   input  logic [ASID_W-1:0] flush_id,
   input  logic              flush_all
);

   localparam int PG_SH = 12;
   localparam int VPN_W = VA_W - PG_SH;
   localparam int PPN_W = PA_W - PG_SH;

   if (VA_W <= PG_SH + SUB_W || PA_W <= PG_SH + SUB_W) begin : g_chk_addr
      $error("asid_tlb: address widths too small for 4 MB pages");
   end
   if (SMALL_N < 2 || LARGE_N < 2) begin : g_chk_n
      $error("asid_tlb: each section needs at least two entries");
   end

   pg_kind_e fill_kind;
   logic     fill_ok;
   assign fill_kind = !fill_large ? PG_4K : (fill_4m ? PG_4M : PG_2M);
   assign fill_ok   = fill_valid && !flush_all;

   logic              hit_s, hit_l;
   logic [PPN_W-1:0]  ppn_s, ppn_l;
   logic [PERM_W-1:0] perm_s, perm_l;

   tlb_section #(
      .N(SMALL_N), .LARGE(1'b0), .VPN_W(VPN_W), .PPN_W(PPN_W),
      .ASID_W(ASID_W), .PERM_W(PERM_W)
   ) u_small (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_vpn     (lk_va[VA_W-1:PG_SH]),
      .lk_asid    (lk_asid),
      .hit        (hit_s),
      .hit_ppn    (ppn_s),
      .hit_perm   (perm_s),
      .fill_vpn   (fill_va[VA_W-1:PG_SH]),
      .fill_ppn   (fill_pa[PA_W-1:PG_SH]),
      .fill_asid  (fill_asid),
      .fill_glb   (fill_global),
      .fill_kind  (fill_kind),
      .fill_perm  (fill_perm),
      .fill_here  (fill_ok && !fill_large),
      .fill_kill  (fill_ok && fill_large),
      .flush_all  (flush_all),
      .flush_id_v (flush_id_valid),
      .flush_id   (flush_id)
   );

   tlb_section #(
      .N(LARGE_N), .LARGE(1'b1), .VPN_W(VPN_W), .PPN_W(PPN_W),
      .ASID_W(ASID_W), .PERM_W(PERM_W)
   ) u_large (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_vpn     (lk_va[VA_W-1:PG_SH]),
      .lk_asid    (lk_asid),
      .hit        (hit_l),
      .hit_ppn    (ppn_l),
      .hit_perm   (perm_l),
      .fill_vpn   (fill_va[VA_W-1:PG_SH]),
      .fill_ppn   (fill_pa[PA_W-1:PG_SH]),
      .fill_asid  (fill_asid),
      .fill_glb   (fill_global),
      .fill_kind  (fill_kind),
      .fill_perm  (fill_perm),
      .fill_here  (fill_ok && fill_large),
      .fill_kill  (fill_ok && !fill_large),
      .flush_all  (flush_all),
      .flush_id_v (flush_id_valid),
      .flush_id   (flush_id)
   );

   logic unused_low_bits;
   assign unused_low_bits = ^{fill_va[PG_SH-1:0], fill_pa[PG_SH-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_pa    <= '0;
         rsp_perm  <= '0;
      end else begin
         rsp_valid <= lk_valid;
         if (lk_valid) begin
            rsp_hit  <= hit_s || hit_l;
            rsp_pa   <= {ppn_s | ppn_l, lk_va[PG_SH-1:0]};
            rsp_perm <= perm_s | perm_l;
         end
      end
   end

   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid); // R2

   AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid); // R2

   AST_ONE_SECTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_s && hit_l)); // R11

endmodule

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [47:0] lk_va = '0;
   logic [7:0]  lk_asid = '0;
   logic        rsp_valid, rsp_hit;
   logic [39:0] rsp_pa;
   logic [3:0]  rsp_perm;
   logic        fill_valid = 1'b0;
   logic [47:0] fill_va = '0;
   logic [39:0] fill_pa = '0;
   logic [7:0]  fill_asid = '0;
   logic        fill_global = 1'b0, fill_large = 1'b0, fill_4m = 1'b0;
   logic [3:0]  fill_perm = '0;
   logic        flush_id_valid = 1'b0;
   logic [7:0]  flush_id = '0;
   logic        flush_all = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   asid_tlb dut (.*);

   typedef struct {
      logic        hit;
      logic [39:0] pa;
      logic [3:0]  perm;
      string       req;
   } exp_t;

   exp_t exp_q[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   task automatic note(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   // Monitor: pops one expectation per response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            note(1'b0, "R2", "response without request", 64'd1, 64'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            note(rsp_hit == e.hit, e.req, "hit", 64'(rsp_hit), 64'(e.hit));
            if (e.hit) begin
               note(rsp_pa == e.pa, e.req, "pa", 64'(rsp_pa), 64'(e.pa));
               note(rsp_perm == e.perm, e.req, "perm", 64'(rsp_perm), 64'(e.perm));
            end
         end
      end
   end

   task automatic lookup(input logic [47:0] va, input logic [7:0] id,
                         input logic h, input logic [39:0] pa,
                         input logic [3:0] perm, input string req);
      exp_t e;
      @(negedge clk);
      lk_valid = 1'b1; lk_va = va; lk_asid = id;
      e.hit = h; e.pa = pa; e.perm = perm; e.req = req;
      exp_q.push_back(e);
      @(posedge clk);
      #1 lk_valid = 1'b0;
   endtask

   task automatic apply(input logic fv, input logic [47:0] va, input logic [39:0] pa,
                        input logic [7:0] id, input logic g, input logic lg,
                        input logic m4, input logic [3:0] perm,
                        input logic fiv, input logic [7:0] fid, input logic fa);
      @(negedge clk);
      fill_valid = fv; fill_va = va; fill_pa = pa; fill_asid = id;
      fill_global = g; fill_large = lg; fill_4m = m4; fill_perm = perm;
      flush_id_valid = fiv; flush_id = fid; flush_all = fa;
      @(posedge clk);
      #1;
      fill_valid = 1'b0; flush_id_valid = 1'b0; flush_all = 1'b0;
   endtask

   task automatic fill(input logic [47:0] va, input logic [39:0] pa, input logic [7:0] id,
                       input logic g, input logic lg, input logic m4, input logic [3:0] perm);
      apply(1'b1, va, pa, id, g, lg, m4, perm, 1'b0, 8'd0, 1'b0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      note(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
      lookup(48'h1234_5678_9ABC, 8'd3, 1'b0, '0, '0, "R1");

      // R3 / R4: small page with identifier
      fill(48'h1234_5678_9000, 40'h12_3456_7000, 8'd3, 1'b0, 1'b0, 1'b0, 4'hB);
      lookup(48'h1234_5678_9ABC, 8'd3, 1'b1, 40'h12_3456_7ABC, 4'hB, "R3");
      lookup(48'h1234_5678_9ABC, 8'd4, 1'b0, '0, '0, "R4");
      lookup(48'h1234_5678_A000, 8'd3, 1'b0, '0, '0, "R3");

      // R5: global entry
      fill(48'h0000_0040_0000, 40'h00_0080_0000, 8'd1, 1'b1, 1'b0, 1'b0, 4'h1);
      lookup(48'h0000_0040_0123, 8'd7, 1'b1, 40'h00_0080_0123, 4'h1, "R5");

      // R6: 2 MB and 4 MB pages with junk in low frame bits
      fill(48'h7F00_0020_0000, 40'h40_0020_1234, 8'd3, 1'b0, 1'b1, 1'b0, 4'h6);
      lookup(48'h7F00_0031_2345, 8'd3, 1'b1, 40'h40_0031_2345, 4'h6, "R6");
      lookup(48'h7F00_0040_0000, 8'd3, 1'b0, '0, '0, "R6");
      fill(48'h6000_0080_0000, 40'h20_0080_0000, 8'd3, 1'b0, 1'b1, 1'b1, 4'h7);
      lookup(48'h6000_00B1_2345, 8'd3, 1'b1, 40'h20_00B1_2345, 4'h7, "R6");
      lookup(48'h6000_00C0_0000, 8'd3, 1'b0, '0, '0, "R6");

      // R7 / R12: identifier flush together with a fill of the same identifier
      fill(48'h0000_0C00_0000, 40'h0C_0000_0000, 8'd5, 1'b0, 1'b0, 1'b0, 4'h5);
      apply(1'b1, 48'h0000_ABCD_E000, 40'hAB_CDEF_0000, 8'd3, 1'b0, 1'b0, 1'b0, 4'h2,
            1'b1, 8'd3, 1'b0);
      lookup(48'h0000_ABCD_E004, 8'd3, 1'b1, 40'hAB_CDEF_0004, 4'h2, "R12");
      lookup(48'h1234_5678_9ABC, 8'd3, 1'b0, '0, '0, "R7");
      lookup(48'h7F00_0031_2345, 8'd3, 1'b0, '0, '0, "R7");
      lookup(48'h6000_00B1_2345, 8'd3, 1'b0, '0, '0, "R7");
      lookup(48'h0000_0C00_0010, 8'd5, 1'b1, 40'h0C_0000_0010, 4'h5, "R7");
      lookup(48'h0000_0040_0123, 8'd9, 1'b1, 40'h00_0080_0123, 4'h1, "R7");

      // R10: refill of a resident page replaces it
      fill(48'h0000_ABCD_E000, 40'h0F_0000_0000, 8'd3, 1'b0, 1'b0, 1'b0, 4'h3);
      lookup(48'h0000_ABCD_E010, 8'd3, 1'b1, 40'h0F_0000_0010, 4'h3, "R10");

      // R11: small page inside a resident large page
      fill(48'h5000_0000_0000, 40'h30_0000_0000, 8'd5, 1'b0, 1'b1, 1'b0, 4'h9);
      lookup(48'h5000_0010_0000, 8'd5, 1'b1, 40'h30_0010_0000, 4'h9, "R11");
      fill(48'h5000_0000_1000, 40'h01_0000_0000, 8'd5, 1'b0, 1'b0, 1'b0, 4'hA);
      lookup(48'h5000_0000_1008, 8'd5, 1'b1, 40'h01_0000_0008, 4'hA, "R11");
      lookup(48'h5000_0010_0000, 8'd5, 1'b0, '0, '0, "R11");

      // R8: full flush beats a same-cycle fill
      apply(1'b1, 48'h0000_0D00_0000, 40'h0D_0000_0000, 8'd5, 1'b0, 1'b0, 1'b0, 4'h4,
            1'b0, 8'd0, 1'b1);
      lookup(48'h0000_0040_0123, 8'd1, 1'b0, '0, '0, "R8");
      lookup(48'h0000_ABCD_E010, 8'd3, 1'b0, '0, '0, "R8");
      lookup(48'h0000_0C00_0010, 8'd5, 1'b0, '0, '0, "R8");
      lookup(48'h0000_0D00_0000, 8'd5, 1'b0, '0, '0, "R8");

      // R9: free slots in order, then round-robin replacement
      for (int k = 0; k < 33; k++) begin
         fill(48'h0000_1000_0000 + (48'(k) << 12), 40'h01_0000_0000 + (40'(k) << 12),
              8'd2, 1'b0, 1'b0, 1'b0, 4'h8);
      end
      lookup(48'h0000_1000_0000, 8'd2, 1'b0, '0, '0, "R9");
      lookup(48'h0000_1000_1004, 8'd2, 1'b1, 40'h01_0000_1004, 4'h8, "R9");
      lookup(48'h0000_1002_0000, 8'd2, 1'b1, 40'h01_0002_0000, 4'h8, "R9");
      fill(48'h0000_1002_1000, 40'h01_0002_1000, 8'd2, 1'b0, 1'b0, 1'b0, 4'h8);
      lookup(48'h0000_1000_1004, 8'd2, 1'b0, '0, '0, "R9");
      lookup(48'h0000_1000_2000, 8'd2, 1'b1, 40'h01_0000_2000, 4'h8, "R9");
      lookup(48'h0000_1002_1000, 8'd2, 1'b1, 40'h01_0002_1000, 4'h8, "R9");

      repeat (4) @(negedge clk);
      note(exp_q.size() == 0, "R2", "responses outstanding",
           64'(exp_q.size()), 64'd0);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule